// File: doc/BRIEF.md
# Interleaved Two-Step Page Program Sequencer

This block produces the order in which the pages of one block of two-bit-per-cell flash get programmed. Each wordline carries a low page (LSB) and a high page (MSB). The LSB step leaves the cells in a temporary, partly programmed state. The MSB step later moves them to their final state. The sequencer interleaves the two steps of neighbouring wordlines. The MSB page of a wordline is issued only after the LSB page of the wordline above it. As a result, each partly programmed wordline receives the steps of both of its neighbours before it is finished.

A pulse on `start` loads the number of wordlines and begins the walk. The block then presents one page at a time: a wordline index, a page-type flag and `valid`. The downstream program engine takes each page by raising `accept` while `valid` is high. Once the final MSB page is accepted, `valid` drops and `done` stays high until the next start. The block issues no flash commands and moves no data. It only tracks its position in the order.

Top module: `pageOrderSeq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `valid` = 0 and `done` = 0. This holds even in the middle of a sequence.
- R2: A `start` pulse taken while idle or done, with `wlCount` in 1..MAX_WL, makes `valid` rise on the next cycle. The first page shown is wordline 0 with `isMsb` = 0. The encoding is `isMsb` = 0 for the LSB page and 1 for the MSB page. `done` is low in that cycle.
- R3: For N wordlines the page order is LSB 0, LSB 1, MSB 0, LSB 2, MSB 1, LSB 3, MSB 2, and so on. Each LSB page of wordline k ≥ 1 is followed directly by the MSB page of wordline k-1.
- R4: The last wordline has no LSB page above it. Its MSB page therefore follows the MSB page of wordline N-2 directly. For N = 1 the order is LSB 0 then MSB 0.
- R5: While `valid` is high and `accept` is low, `wlIdx` and `isMsb` hold their values and `valid` stays high.
- R6: The position advances by exactly one page on each clock edge where `valid` and `accept` are both high. A sequence has exactly 2·N pages.
- R7: After the final MSB page is accepted, the next cycle shows `valid` = 0 and `done` = 1. `done` stays high until reset or a new start is taken.
- R8: A `start` pulse, or a change on `wlCount`, while `valid` is high has no effect on the order being emitted.
- R9: A `start` pulse with `wlCount` = 0 is ignored. The block stays idle, or stays done, with `valid` low.
- R10: A `wlCount` above MAX_WL is treated as MAX_WL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse; begins a sequence when idle or done |
| wlCount | input | $clog2(MAX_WL+1) | Number of wordlines, sampled with the start pulse |
| accept | input | 1 | Downstream takes the shown page when high together with valid |
| valid | output | 1 | A page is being shown |
| wlIdx | output | $clog2(MAX_WL) | Wordline index of the shown page |
| isMsb | output | 1 | 0 = LSB page, 1 = MSB page |
| done | output | 1 | The last page was accepted; held until the next start |

## Verification
The position register can go wrong in two ways: it can step to the wrong successor, or it can fail to see the last wordline. Either fault shows at the ports as a wrong index or page flag, one cycle after the accepting edge. A wrong end-of-block decision appears either as `valid` dropping early or as an index running past N-1. Both appear within the last three pages of the sequence. Control-state faults show up on the cycle after the event: a start that is not ignored resets the index to 0, and a stalled cycle that advances skips a page.

// File: rtl/pageSeqPkg.sv
package pageSeqPkg;

  // Strobes from the control FSM to the position datapath.
  typedef struct packed {
    logic load;   // capture wordline count, go to first page
    logic step;   // move to the next page in interleaved order
  } seqStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_DONE = 2'd2
  } seqState_t;

endpackage

// File: rtl/pageSeqPath.sv
module pageSeqPath
  import pageSeqPkg::*;
#(
  parameter int MAX_WL = 64,
  parameter int CNT_W  = $clog2(MAX_WL + 1),
  parameter int IDX_W  = (MAX_WL > 1) ? $clog2(MAX_WL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       strobe,
  input  logic [CNT_W-1:0] cntIn,
  output logic [IDX_W-1:0] curWl,
  output logic             curMsb,
  output logic             isFinal
);

  localparam int EXT_W = IDX_W + 2;

  logic [IDX_W-1:0] lastWl;
  logic [CNT_W-1:0] cntClamp;
  logic [IDX_W-1:0] nextWl;
  logic             nextMsb;
  logic [EXT_W-1:0] curExt;
  logic [EXT_W-1:0] lastExt;

  // Clamp the requested count; the stored value is the top wordline index.
  always_comb begin
    if (cntIn > CNT_W'(MAX_WL)) cntClamp = CNT_W'(MAX_WL);
    else                        cntClamp = cntIn;
  end

  assign curExt  = EXT_W'(curWl);
  assign lastExt = EXT_W'(lastWl);

  // Successor in the interleaved order.
  always_comb begin
    nextWl  = curWl;
    nextMsb = curMsb;
    if (!curMsb) begin
      if (curWl == '0) begin
        if (lastWl == '0) nextMsb = 1'b1;          // single wordline
        else              nextWl  = IDX_W'(1);     // LSB 0 -> LSB 1
      end else begin
        nextWl  = curWl - IDX_W'(1);               // LSB k -> MSB k-1
        nextMsb = 1'b1;
      end
    end else begin
      if (curExt + EXT_W'(2) <= lastExt) begin
        nextWl  = curWl + IDX_W'(2);               // MSB k -> LSB k+2
        nextMsb = 1'b0;
      end else begin
        nextWl  = curWl + IDX_W'(1);               // tail: MSB k -> MSB k+1
        nextMsb = 1'b1;
      end
    end
  end

  assign isFinal = curMsb && (curWl == lastWl);

  always_ff @(posedge clk) begin
    if (rst) begin
      curWl  <= '0;
      curMsb <= 1'b0;
      lastWl <= '0;
    end else if (strobe.load) begin
      curWl  <= '0;
      curMsb <= 1'b0;
      lastWl <= IDX_W'(cntClamp - CNT_W'(1));
    end else if (strobe.step) begin
      curWl  <= nextWl;
      curMsb <= nextMsb;
    end
  end

  AST_LSB_TO_LOWER_MSB: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && !curMsb && curWl != '0)
      |=> (curMsb && curWl == $past(curWl) - IDX_W'(1))) else $error("AST_LSB_TO_LOWER_MSB"); // R3

  AST_MSB_SUCCESSOR: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && curMsb)
      |=> ((!curMsb && curWl == $past(curWl) + IDX_W'(2)) ||
           (curMsb && curWl == $past(curWl) + IDX_W'(1)))) else $error("AST_MSB_SUCCESSOR"); // R4

  AST_FIRST_LSB_UP: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && !curMsb && curWl == '0)
      |=> ((!curMsb && curWl == IDX_W'(1)) || (curMsb && curWl == '0))) else $error("AST_FIRST_LSB_UP"); // R3

endmodule

// File: rtl/pageSeqCtrl.sv
module pageSeqCtrl
  import pageSeqPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       cntNonZero,
  input  logic       accept,
  input  logic       isFinal,
  output seqStrobe_t strobe,
  output logic       valid,
  output logic       done
);

  seqState_t state;
  seqState_t stateNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      S_IDLE, S_DONE: begin
        if (start && cntNonZero) begin
          strobe.load = 1'b1;
          stateNxt    = S_RUN;
        end
      end
      S_RUN: begin
        if (accept) begin
          if (isFinal) stateNxt    = S_DONE;
          else         strobe.step = 1'b1;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNxt;
  end

  assign valid = (state == S_RUN);
  assign done  = (state == S_DONE);

  AST_RUN_UNTIL_FINAL: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN && !(accept && isFinal)) |=> (state == S_RUN)) else $error("AST_RUN_UNTIL_FINAL"); // R8

  AST_ZERO_COUNT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state != S_RUN && !(start && cntNonZero)) |=> (state == $past(state))) else $error("AST_ZERO_COUNT_IGNORED"); // R9

endmodule

// File: rtl/pageOrderSeq.sv
module pageOrderSeq
  import pageSeqPkg::*;
#(
  parameter int MAX_WL = 64,
  localparam int CNT_W = $clog2(MAX_WL + 1),
  localparam int IDX_W = (MAX_WL > 1) ? $clog2(MAX_WL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] wlCount,
  input  logic             accept,
  output logic             valid,
  output logic [IDX_W-1:0] wlIdx,
  output logic             isMsb,
  output logic             done
);

  seqStrobe_t strobe;
  logic       isFinal;
  logic       cntNonZero;

  assign cntNonZero = (wlCount != '0);

  pageSeqCtrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cntNonZero (cntNonZero),
    .accept     (accept),
    .isFinal    (isFinal),
    .strobe     (strobe),
    .valid      (valid),
    .done       (done)
  );

  pageSeqPath #(
    .MAX_WL (MAX_WL),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W)
  ) u_path (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .cntIn   (wlCount),
    .curWl   (wlIdx),
    .curMsb  (isMsb),
    .isFinal (isFinal)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!valid && !done)) else $error("AST_RESET_QUIET"); // R1

  AST_FIRST_PAGE: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> (wlIdx == '0 && !isMsb && !done)) else $error("AST_FIRST_PAGE"); // R2

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (valid && !accept) |=> (valid && $stable(wlIdx) && $stable(isMsb))) else $error("AST_HOLD_STALL"); // R5

  AST_DONE_AFTER_MSB: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(valid && accept && isMsb)) else $error("AST_DONE_AFTER_MSB"); // R7

endmodule

// File: tb/tb_pageOrderSeq.sv
module tb_pageOrderSeq;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_WL     = 64;
  localparam int CNT_W      = $clog2(MAX_WL + 1);
  localparam int IDX_W      = $clog2(MAX_WL);
  localparam int WATCHDOG   = 150000;

  logic             clk = 1'b0;
  logic             rst;
  logic             start;
  logic [CNT_W-1:0] wlCount;
  logic             accept;
  logic             valid;
  logic [IDX_W-1:0] wlIdx;
  logic             isMsb;
  logic             done;

  int checks = 0;
  int errors = 0;

  pageOrderSeq #(.MAX_WL(MAX_WL)) dut (
    .clk(clk), .rst(rst), .start(start), .wlCount(wlCount), .accept(accept),
    .valid(valid), .wlIdx(wlIdx), .isMsb(isMsb), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected wordline and page type of position i in an n-wordline walk.
  function automatic int expWl(int n, int i);
    if (i == 0)         return 0;
    if (i == 2*n - 1)   return n - 1;
    if (i % 2 == 1)     return (i + 1) / 2;
    return i / 2 - 1;
  endfunction

  function automatic int expMsb(int n, int i);
    if (i == 0)         return 0;
    if (i == 2*n - 1)   return 1;
    return (i % 2 == 0) ? 1 : 0;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  // Run one sequence; stallPct = percent of cycles with accept low.
  task automatic runSeq(int cntReq, int stallPct, bit poke);
    int n;
    int idx;
    int guard;
    bit acc;
    bit prevStall;
    string req;
    n = (cntReq > MAX_WL) ? MAX_WL : cntReq;
    @(negedge clk);
    start = 1'b1; wlCount = CNT_W'(cntReq);
    @(negedge clk);
    start = 1'b0; wlCount = CNT_W'($urandom_range(1, MAX_WL));
    check(done == 1'b0, "R2", "done after start", int'(done), 0);
    idx = 0; guard = 0; prevStall = 1'b0;
    while (idx < 2*n && guard < 20000) begin
      if (idx == 0)          req = "R2";
      else if (idx == 2*n-1) req = "R4";
      else if (prevStall)    req = "R5";
      else                   req = "R3";
      if (cntReq > MAX_WL)   req = {req, "/R10"};
      if (poke)              req = {req, "/R8"};
      check(valid == 1'b1, req, "valid during walk", int'(valid), 1);
      check(int'(wlIdx) == expWl(n, idx), req, "wordline index", int'(wlIdx), expWl(n, idx));
      check(int'(isMsb) == expMsb(n, idx), req, "page type", int'(isMsb), expMsb(n, idx));
      acc    = ($urandom_range(0, 99) >= stallPct);
      accept = acc;
      start  = poke && ($urandom_range(0, 2) == 0);
      wlCount = CNT_W'($urandom_range(0, MAX_WL));
      @(negedge clk);
      start = 1'b0;
      if (acc) idx++;
      prevStall = !acc;
      guard++;
    end
    accept = 1'b0;
    check(idx == 2*n, "R6", "pages walked", idx, 2*n);
    check(valid == 1'b0, "R7", "valid after last page", int'(valid), 0);
    check(done == 1'b1, "R7", "done after last page", int'(done), 1);
    repeat (2) @(negedge clk);
    check(done == 1'b1, "R7", "done held", int'(done), 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; start = 1'b0; wlCount = '0; accept = 1'b0;
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R1", "valid in reset", int'(valid), 0);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rst = 1'b0;

    // Zero count while idle
    @(negedge clk); start = 1'b1; wlCount = '0;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check(valid == 1'b0, "R9", "valid after zero-count start", int'(valid), 0);
    check(done == 1'b0, "R9", "done after zero-count start", int'(done), 0);

    runSeq(1, 0, 1'b0);     // R4 single wordline
    runSeq(2, 30, 1'b0);
    runSeq(3, 50, 1'b1);    // R8 starts during walk

    // Zero count while done
    @(negedge clk); start = 1'b1; wlCount = '0;
    @(negedge clk); start = 1'b0;
    check(valid == 1'b0, "R9", "valid after zero start in done", int'(valid), 0);
    check(done == 1'b1, "R9", "done kept after zero start", int'(done), 1);

    runSeq(100, 20, 1'b1);  // R10 clamp
    runSeq(MAX_WL, 10, 1'b0);

    for (int k = 0; k < 12; k++) begin
      runSeq($urandom_range(1, MAX_WL), $urandom_range(0, 70), bit'($urandom_range(0, 1)));
    end

    // Reset in the middle of a walk
    @(negedge clk); start = 1'b1; wlCount = CNT_W'(5);
    @(negedge clk); start = 1'b0; accept = 1'b1;
    repeat (3) @(negedge clk);
    accept = 1'b0; rst = 1'b1;
    @(negedge clk);
    check(valid == 1'b0, "R1", "valid after mid reset", int'(valid), 0);
    check(done == 1'b0, "R1", "done after mid reset", int'(done), 0);
    rst = 1'b0;
    runSeq(4, 40, 1'b0);

    summary();
  end

endmodule